// File: doc/BRIEF.md
# Shared-Multiplier Laguerre Convolution Unit

This block updates the three recursive Laguerre convolution values of one signal in each three-clock convolution period. It also folds each new value, weighted, into the membrane-potential sum of the channel being evaluated. In the first three clocks of a period the caller presents the previous-step values of orders one, two and three, one per clock, together with the weight for each order. The block writes back the new value of each order in turn. A single spike bit, captured when the period starts, decides whether each order's additive constant is applied. No multiplication by the spike is performed. The bit only gates the constant path, so the adder input stays quiet while the spike is zero.

Three multipliers are shared across the orders. A three-stage tap chain moves the previous values one place per clock. The first tap is always scaled by Q1, the second by Q3 and the third by Q5. Summing the three products therefore yields order one, two or three depending on how far the chain has filled.

A channel spans `NUM_IN + 1` periods. The first `NUM_IN` periods use the external input constant set. The final period handles the channel's own previous output and uses the feedback constant set. The sum starts from a bias and is presented with a one-cycle strobe when the channel ends. All data is signed Q2.14.

Top module: `lag_conv_unit`

The control state machine has four states:
- IDLE: no period is running.
- ORD1: the cycle that computes order one.
- ORD2: the cycle that computes order two.
- ORD3: the cycle that computes order three.

Its transitions are:
- IDLE→ORD1 on an accepted start (start_go).
- ORD1→ORD2 unconditionally (step_a).
- ORD2→ORD3 unconditionally (step_b).
- ORD3→ORD1 when a start arrives (chain_go); this gives back-to-back periods.
- ORD3→IDLE otherwise (rest).

## Requirements
- R1: After reset `wr_en_o` and `sum_valid_o` are 0 and no period is in progress.
- R2: A period starts when `start_i` is 1 in an idle cycle or in the last cycle of a period. `state_i` and `weight_i` carry order 1, 2 and 3 in that cycle and the next two. The write-back of order k (`wr_ord_o` = 0, 1, 2 for orders 1, 2, 3) appears with `wr_en_o` = 1 two cycles after its previous value was presented, in three consecutive cycles.
- R3: Let rs(s) = saturate((s + 2^13) >>> 14) to [-32768, 32767]. With spike 0 the new values are rs(Q1·v1'), rs(Q3·v1' + Q1·v2') and rs(Q5·v1' + Q3·v2' + Q1·v3').
- R4: `spike_i` is sampled only in the start cycle. When it is 1, Q2, Q4 or Q6 is added to orders 1, 2 and 3 respectively, after rounding, with saturation to 16 bits. When it is 0, nothing is added.
- R5: Constant Qn occupies bits [16n-1:16(n-1)] of a constant bus. Periods 0 to NUM_IN-1 of a channel use `q_in_i`; period NUM_IN uses `q_fb_i`.
- R6: `start_i` in the second or third cycle of a period has no effect.
- R7: At the start of a channel's first period the sum is loaded with `bias_i`. Each write-back adds floor(weight·v / 2^14). Together with the last write-back of the channel's final period, `sum_valid_o` pulses for one cycle and `sum_o` holds the total.
- R8: Periods may run back to back with no idle cycle, or with idle cycles between them. The channel position is kept across idle gaps.
- R9: After NUM_IN+1 periods the channel position wraps. The next channel starts again from its own `bias_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Period-start strobe |
| state_i | input | 16 | Previous-step value of the order presented this cycle |
| weight_i | input | 16 | Weight of the order presented this cycle |
| spike_i | input | 1 | Spike bit of the signal, sampled with the start |
| bias_i | input | 32 | Channel bias in Q.14, loaded at channel start |
| q_in_i | input | 96 | Constants Q1..Q6 for the input signals |
| q_fb_i | input | 96 | Constants Q1..Q6 for the feedback signal |
| wr_en_o | output | 1 | Write-back valid |
| wr_ord_o | output | 2 | Order of the write-back (0, 1, 2) |
| wr_data_o | output | 16 | New convolution value |
| sum_o | output | 32 | Accumulated membrane potential |
| sum_valid_o | output | 1 | One-cycle strobe for `sum_o` |

## Verification
The bench builds the unit with NUM_IN = 3, so each channel is four periods long. This keeps the feedback constant set, the channel wrap and the bias reload within a few dozen cycles. Widths stay at their defaults, with 16-bit Q2.14 data and a 32-bit sum. This lets a third channel drive all the multiplied constants and the states to their extremes, which exercises positive and negative saturation, including saturation of the constant addition. A behavioural model predicts every output on every clock, through back-to-back periods, idle gaps, a stray start in mid-period and a spike bit that changes after the start cycle.

// File: rtl/lag_pkg.sv
package lag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ORD1 = 2'd1,
        ST_ORD2 = 2'd2,
        ST_ORD3 = 2'd3
    } lag_state_e;

    localparam int NUM_Q = 6;

endpackage

// File: rtl/lag_tap_chain.sv
module lag_tap_chain #(
    parameter int W    = 16,
    parameter int TAPS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                shf_i,
    input  logic [W-1:0]        d_i,
    output logic [TAPS*W-1:0]   taps_o
);

    logic [W-1:0] tap_q [TAPS];

    // Tap 0 always takes the new previous value; deeper taps either restart
    // from zero (first order of a period) or move one place down the chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
        end else if (clr_i) begin
            tap_q[0] <= d_i;
            for (int i = 1; i < TAPS; i++) tap_q[i] <= '0;
        end else if (shf_i) begin
            tap_q[0] <= d_i;
            for (int i = 1; i < TAPS; i++) tap_q[i] <= tap_q[i-1];
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_out
        assign taps_o[g*W +: W] = tap_q[g];
    end

endmodule

// File: rtl/lag_order_calc.sv
module lag_order_calc #(
    parameter int W = 16,
    parameter int F = 14
) (
    input  logic [W-1:0] t1_i,
    input  logic [W-1:0] t2_i,
    input  logic [W-1:0] t3_i,
    input  logic [W-1:0] qa_i,
    input  logic [W-1:0] qb_i,
    input  logic [W-1:0] qc_i,
    input  logic [W-1:0] qk_i,
    input  logic         spike_i,
    output logic [W-1:0] v_o
);

    localparam int PW = 2 * W;
    localparam int SW = PW + 2;
    localparam logic signed [SW-1:0] HALF = SW'(2 ** (F - 1));
    localparam logic signed [SW-1:0] VMAX = SW'(2 ** (W - 1) - 1);
    localparam logic signed [SW-1:0] VMIN = -VMAX - SW'(1);

    logic signed [PW-1:0] p1, p2, p3;
    logic signed [SW-1:0] psum, prnd;
    logic signed [W-1:0]  vsat, kgate;
    logic signed [W:0]    vadd;

    assign p1 = $signed(qa_i) * $signed(t1_i);
    assign p2 = $signed(qb_i) * $signed(t2_i);
    assign p3 = $signed(qc_i) * $signed(t3_i);

    assign psum = SW'(p1) + SW'(p2) + SW'(p3);
    assign prnd = (psum + HALF) >>> F;

    always_comb begin
        if (prnd > VMAX)      vsat = VMAX[W-1:0];
        else if (prnd < VMIN) vsat = VMIN[W-1:0];
        else                  vsat = prnd[W-1:0];
    end

    // Operand isolation: the constant only reaches the adder with a spike.
    assign kgate = $signed(qk_i & {W{spike_i}});
    assign vadd  = {vsat[W-1], vsat} + {kgate[W-1], kgate};

    always_comb begin
        if (vadd[W] != vadd[W-1]) v_o = vadd[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else                      v_o = vadd[W-1:0];
    end

endmodule

// File: rtl/lag_mac.sv
module lag_mac #(
    parameter int W     = 16,
    parameter int F     = 14,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [W-1:0]     w_i,
    input  logic [W-1:0]     v_i,
    input  logic             acc_en_i,
    input  logic             init_en_i,
    input  logic [ACC_W-1:0] bias_i,
    input  logic             fin_en_i,
    output logic [ACC_W-1:0] sum_o,
    output logic             sum_valid_o
);

    localparam int PW = 2 * W;

    logic [W-1:0]             w_q;
    logic signed [PW-1:0]     prod, pshift;
    logic signed [ACC_W-1:0]  pext, acc_q, acc_nx;

    assign prod   = $signed(w_q) * $signed(v_i);
    assign pshift = prod >>> F;
    assign pext   = ACC_W'(pshift);
    assign acc_nx = acc_q + pext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q         <= '0;
            acc_q       <= '0;
            sum_o       <= '0;
            sum_valid_o <= 1'b0;
        end else begin
            if (ld_i) w_q <= w_i;
            if (init_en_i)     acc_q <= $signed(bias_i);
            else if (acc_en_i) acc_q <= acc_nx;
            sum_valid_o <= fin_en_i;
            if (fin_en_i) sum_o <= acc_nx;
        end
    end

endmodule

// File: rtl/lag_conv_unit.sv
module lag_conv_unit
    import lag_pkg::*;
#(
    parameter int W      = 16,
    parameter int F      = 14,
    parameter int ACC_W  = 32,
    parameter int NUM_IN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [W-1:0]         state_i,
    input  logic [W-1:0]         weight_i,
    input  logic                 spike_i,
    input  logic [ACC_W-1:0]     bias_i,
    input  logic [NUM_Q*W-1:0]   q_in_i,
    input  logic [NUM_Q*W-1:0]   q_fb_i,
    output logic                 wr_en_o,
    output logic [1:0]           wr_ord_o,
    output logic [W-1:0]         wr_data_o,
    output logic [ACC_W-1:0]     sum_o,
    output logic                 sum_valid_o
);

    localparam int NUM_SIG = NUM_IN + 1;
    localparam int IDX_W   = $clog2(NUM_SIG);
    localparam int TAPS    = 3;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SIG - 1);

    lag_state_e st_q, st_d;
    logic [IDX_W-1:0]    sig_q;
    logic                spk_q;
    logic                start_ok, computing, last_sig, first_sig, shf;
    logic [NUM_Q*W-1:0]  qset;
    logic [W-1:0]        qk;
    logic [1:0]          ord_k;
    logic [TAPS*W-1:0]   taps;
    logic [W-1:0]        v_new;

    assign start_ok  = start_i && (st_q == ST_IDLE || st_q == ST_ORD3);
    assign computing = (st_q != ST_IDLE);
    assign shf       = (st_q == ST_ORD1) || (st_q == ST_ORD2);
    assign last_sig  = (sig_q == LAST_IDX);
    assign first_sig = (st_q == ST_ORD3) ? last_sig : (sig_q == '0);
    assign qset      = last_sig ? q_fb_i : q_in_i;

    always_comb begin
        unique case (st_q)
            ST_ORD2: begin ord_k = 2'd1; qk = qset[3*W +: W]; end
            ST_ORD3: begin ord_k = 2'd2; qk = qset[5*W +: W]; end
            default: begin ord_k = 2'd0; qk = qset[1*W +: W]; end
        endcase
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start_i) st_d = ST_ORD1;
            ST_ORD1: st_d = ST_ORD2;
            ST_ORD2: st_d = ST_ORD3;
            ST_ORD3: st_d = start_i ? ST_ORD1 : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            sig_q <= '0;
            spk_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start_ok) spk_q <= spike_i;
            if (st_q == ST_ORD3) sig_q <= last_sig ? '0 : sig_q + 1'b1;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_ord_o  <= 2'd0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= computing;
            if (computing) begin
                wr_ord_o  <= ord_k;
                wr_data_o <= v_new;
            end
        end
    end

    lag_tap_chain #(.W(W), .TAPS(TAPS)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_ok),
        .shf_i  (shf),
        .d_i    (state_i),
        .taps_o (taps)
    );

    lag_order_calc #(.W(W), .F(F)) u_calc (
        .t1_i    (taps[0 +: W]),
        .t2_i    (taps[W +: W]),
        .t3_i    (taps[2*W +: W]),
        .qa_i    (qset[0 +: W]),
        .qb_i    (qset[2*W +: W]),
        .qc_i    (qset[4*W +: W]),
        .qk_i    (qk),
        .spike_i (spk_q),
        .v_o     (v_new)
    );

    lag_mac #(.W(W), .F(F), .ACC_W(ACC_W)) u_mac (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_i        (start_ok || shf),
        .w_i         (weight_i),
        .v_i         (v_new),
        .acc_en_i    (computing),
        .init_en_i   (start_ok && first_sig),
        .bias_i      (bias_i),
        .fin_en_i    ((st_q == ST_ORD3) && last_sig),
        .sum_o       (sum_o),
        .sum_valid_o (sum_valid_o)
    );

endmodule

// File: rtl/lag_conv_chk.sv
module lag_conv_chk
    import lag_pkg::*;
#(
    parameter int IDX_W   = 7,
    parameter int NUM_SIG = 65
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_o,
    input logic [1:0]       wr_ord_o,
    input logic             sum_valid_o,
    input lag_state_e       st,
    input logic [IDX_W-1:0] sig_idx
);

    // R2
    ord_one_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_ord_o == 2'd0) |=> (wr_en_o && wr_ord_o == 2'd1));

    // R2
    ord_two_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_ord_o == 2'd1) |=> (wr_en_o && wr_ord_o == 2'd2));

    // R2
    ord_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_ord_o != 2'd3));

    // R6
    mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ORD1) |=> (st == ST_ORD2));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid_o |=> !sum_valid_o);

    // R7
    valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid_o |-> (wr_en_o && wr_ord_o == 2'd2));

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sig_idx) < NUM_SIG);

endmodule

bind lag_conv_unit lag_conv_chk #(.IDX_W(IDX_W), .NUM_SIG(NUM_SIG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_o     (wr_en_o),
    .wr_ord_o    (wr_ord_o),
    .sum_valid_o (sum_valid_o),
    .st          (st_q),
    .sig_idx     (sig_q)
);

// File: tb/lag_conv_unit_test.sv
module lag_conv_unit_test;

    localparam int W = 16, F = 14, AW = 32, NIN = 3, NSIG = NIN + 1;

    logic clk = 0, rst_n = 0;
    logic start_i = 0, spike_i = 0;
    logic [W-1:0] state_i = '0, weight_i = '0;
    logic [AW-1:0] bias_i = '0;
    logic [6*W-1:0] q_in_v, q_fb_v;
    logic wr_en_o, sum_valid_o;
    logic [1:0] wr_ord_o;
    logic [W-1:0] wr_data_o;
    logic [AW-1:0] sum_o;

    int qx[1:6], qf[1:6];
    int checks = 0, bad = 0, wr_seen = 0;
    bit run_cmp = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 1; i <= 6; i++) begin
            q_in_v[16*(i-1) +: 16] = 16'(qx[i]);
            q_fb_v[16*(i-1) +: 16] = 16'(qf[i]);
        end
    end

    lag_conv_unit #(.W(W), .F(F), .ACC_W(AW), .NUM_IN(NIN)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .state_i(state_i),
        .weight_i(weight_i), .spike_i(spike_i), .bias_i(bias_i),
        .q_in_i(q_in_v), .q_fb_i(q_fb_v), .wr_en_o(wr_en_o),
        .wr_ord_o(wr_ord_o), .wr_data_o(wr_data_o), .sum_o(sum_o),
        .sum_valid_o(sum_valid_o)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint sat16(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    // behavioural reference
    int ph = 0, sig = 0, chan = 0;
    bit spk = 0;
    longint h[3], wv[3], acc = 0;
    bit e_we = 0, e_vld = 0;
    longint e_data = 0, e_sum = 0;
    int e_ord = 0;
    string e_tag = "R3", e_stag = "R7";

    always @(posedge clk) begin
        longint s, r, add;
        int k;
        int qq[1:6];
        if (!rst_n) begin
            ph = 0; sig = 0; acc = 0; e_we = 0; e_vld = 0; spk = 0; chan = 0;
        end else begin
            e_we = 0; e_vld = 0; add = 0;
            if (ph != 0) begin
                k = ph - 1;
                qq = (sig == NSIG - 1) ? qf : qx;
                s = longint'(qq[1]) * h[k];
                if (k >= 1) s += longint'(qq[3]) * h[k-1];
                if (k >= 2) s += longint'(qq[5]) * h[k-2];
                r = sat16((s + 8192) >>> 14);
                if (spk) r = sat16(r + qq[2*k+2]);
                e_we = 1; e_data = r; e_ord = k;
                e_tag = (sig == NSIG - 1) ? "R5" : (spk ? "R4" : "R3");
                add = (wv[k] * r) >>> 14;
                if (ph == 3 && sig == NSIG - 1) begin
                    e_vld = 1; e_sum = acc + add;
                    e_stag = (chan == 0) ? "R7" : "R9";
                end
                acc += add;
            end
            if (ph == 1) begin
                h[1] = longint'($signed(state_i)); wv[1] = longint'($signed(weight_i)); ph = 2;
            end else if (ph == 2) begin
                h[2] = longint'($signed(state_i)); wv[2] = longint'($signed(weight_i)); ph = 3;
            end else begin
                if (ph == 3) begin
                    if (sig == NSIG - 1) begin sig = 0; chan++; end
                    else sig++;
                end
                if (start_i) begin
                    h[0] = longint'($signed(state_i)); wv[0] = longint'($signed(weight_i));
                    spk = spike_i;
                    if (sig == 0) acc = longint'($signed(bias_i));
                    ph = 1;
                end else ph = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk("R2 wr_en", longint'(wr_en_o), longint'(e_we));
            if (e_we) begin
                chk(e_tag, longint'($signed(wr_data_o)), e_data);
                chk("R2 order", longint'(wr_ord_o), longint'(e_ord));
            end
            chk(e_stag, longint'(sum_valid_o), longint'(e_vld));
            if (e_vld) chk(e_stag, longint'($signed(sum_o)), e_sum);
            if (wr_en_o) wr_seen++;
        end
    end

    function automatic int sv(int i);
        return ((i * 12345 + 678) % 50001) - 25000;
    endfunction

    task automatic period(bit spkb, int a, int b, int c, int wa, int wb, int wc, bit stray);
        @(negedge clk); start_i = 1; state_i = 16'(a); weight_i = 16'(wa); spike_i = spkb;
        @(negedge clk); start_i = stray; state_i = 16'(b); weight_i = 16'(wb); spike_i = !spkb;
        @(negedge clk); start_i = 0; state_i = 16'(c); weight_i = 16'(wc);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); start_i = 0; state_i = '0; weight_i = '0;
        end
    endtask

    initial begin
        qx = '{9830, 13107, 13107, -7864, 4915, 10486};
        qf = '{4915, 15630, 15630, -3200, 1475, 14000};
        repeat (3) @(negedge clk);
        // R1: outputs quiet during and right after reset
        chk("R1", longint'(wr_en_o), 0);
        chk("R1", longint'(sum_valid_o), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", longint'(wr_en_o), 0);
        chk("R1", longint'(sum_valid_o), 0);
        run_cmp = 1;

        // channel 0: back to back, stray start in period 1 (R6)
        bias_i = 32'(1000);
        wr_seen = 0;
        for (int p = 0; p < NSIG; p++)
            period(p != 1, sv(3*p), sv(3*p+1), sv(3*p+2), sv(40+p) / 2, sv(50+p) / 2, sv(60+p) / 2, p == 1);
        idle(5);
        chk("R6 write count", wr_seen, 3 * NSIG);
        chk("R8 back-to-back writes", wr_seen, 3 * NSIG);

        // channel 1: idle gaps between periods, new bias (R8, R9)
        bias_i = -32'sd5000;
        wr_seen = 0;
        for (int p = 0; p < NSIG; p++) begin
            period(p[0], sv(7*p+5), sv(7*p+6), sv(7*p+9), sv(90+p), sv(95+p), sv(99+p), 0);
            idle(p + 1);
        end
        idle(3);
        chk("R8 gapped writes", wr_seen, 3 * NSIG);

        // channel 2: saturation of products and of constant addition (R3, R4)
        qx = '{32767, 32767, 32767, 32767, 32767, -32768};
        qf = '{32767, -32768, 32767, -32768, 32767, -32768};
        bias_i = '0;
        period(1, 32767, 32767, 32767, 16384, 16384, 16384, 0);
        period(0, -32768, -32768, -32768, 16384, -16384, 100, 0);
        period(1, -32768, 32767, -32768, 200, 300, 400, 0);
        period(1, -32768, -32768, 32767, 1, 2, 3, 0);
        idle(6);

        run_cmp = 0;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule